// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write cycles that a host issues to a parallel x16 NOR flash. Each cycle that the bus interface samples (address, data, a one-cycle valid strobe) is matched against the protected multi-cycle sequences. Every accepted command produces a one-cycle pulse towards the program/erase engine, together with the target address and, for a program, the data word. The storage array, analog timing and read data path live elsewhere.

Two unlock cycles (AAH at word address 5555H, then 55H at 2AAAH) precede every protected command. The third cycle carries the command byte at 5555H. Erase commands repeat the unlock pair after an 80H setup byte and name the erase type in the sixth cycle. The engine reports its state on three inputs: program running, erase running, erase suspended. The decoder uses them to lock out commands and to gate suspend and resume. A write-protect pin guards one 32 KWord boot block, at the bottom or the top of the array as chosen by a parameter.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The sequence AAH@5555H, 55H@2AAAH, A0H@5555H, then any write, pulses cmd_prog in the cycle after the fourth write. op_addr and op_data carry that write's address and full 16-bit data.
- R2: The six-cycle form AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH, 30H@addr pulses cmd_sec_erase. op_addr is addr with its low 11 bits cleared, which gives a 2 KWord sector base.
- R3: The same six-cycle form ending in 50H@addr pulses cmd_blk_erase. op_addr is addr with its low 15 bits cleared, which gives a 32 KWord block base.
- R4: The six-cycle form ending in 10H pulses cmd_chip_erase only when that cycle's address is 5555H. 10H at any other address produces nothing.
- R5: A single B0H write at any address pulses cmd_suspend only while ers_busy is high. A single 30H write at any address, from the idle sequence state, pulses cmd_resume only while ers_susp is high.
- R6: A three-cycle unlock form ending in 98H@5555H pulses cmd_query_enter. One ending in 88H pulses cmd_secid_enter. One ending in F0H, or a single F0H write from idle, pulses cmd_exit.
- R7: A cycle that does not continue the sequence in progress returns the decoder to idle and produces no pulse. That cycle is not reinterpreted as the start of a new command.
- R8: While pgm_busy or ers_busy is high, every write, including an exit, produces no pulse and leaves the decoder idle. The one exception is the suspend of R5.
- R9: With wp_n low, a program, sector erase or block erase whose address lies in the boot block produces no pulse, and a chip erase produces no pulse at all. Targets outside the boot block are unaffected. With wp_n high, the boot block is writable.
- R10: With BOOT_TOP=0 the boot block is word addresses 000000H to 007FFFH. With BOOT_TOP=1 it is the highest 32 KWord of the address space.
- R11: Only data bits 7:0 are decoded in command cycles. Bits 15:8 have no effect on sequence matching.
- R12: While ers_susp is high, a completed erase sequence produces no pulse, but a program sequence is accepted.
- R13: At most one command pulse is high in any cycle, and pulses appear only in the cycle after a sampled write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe for a sampled bus write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data word of the write |
| wp_n | input | 1 | Boot-block write protect, active low |
| pgm_busy | input | 1 | Internal program running |
| ers_busy | input | 1 | Internal erase running |
| ers_susp | input | 1 | An erase is suspended |
| cmd_prog | output | 1 | Word program pulse |
| cmd_sec_erase | output | 1 | Sector erase pulse |
| cmd_blk_erase | output | 1 | Block erase pulse |
| cmd_chip_erase | output | 1 | Chip erase pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| cmd_query_enter | output | 1 | Enter query mode pulse |
| cmd_secid_enter | output | 1 | Enter security-ID mode pulse |
| cmd_exit | output | 1 | Return to read mode pulse |
| op_addr | output | ADDR_W | Target address, aligned per erase type |
| op_data | output | DATA_W | Program data word |

## Verification
Two pairs of functions can meet in one write cycle. The first is the busy lockout and suspend acceptance: a B0H written while an erase runs must pass, while the same byte during a program, or an exit during an erase, must not. The second is sequence abort and resume: with an erase suspended, a 30H written right after an unlock byte must only abort, while the next 30H from idle must resume. The bench provokes each by holding the engine status inputs steady across the write and compares the single pulse, or its absence, against the queued expectation.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   localparam logic [15:0] ADR_CMD = 16'h5555;
   localparam logic [15:0] ADR_UNL = 16'h2AAA;

   localparam logic [7:0] OP_UNL1   = 8'hAA;
   localparam logic [7:0] OP_UNL2   = 8'h55;
   localparam logic [7:0] OP_PROG   = 8'hA0;
   localparam logic [7:0] OP_SETUP  = 8'h80;
   localparam logic [7:0] OP_SEC    = 8'h30;
   localparam logic [7:0] OP_BLK    = 8'h50;
   localparam logic [7:0] OP_CHIP   = 8'h10;
   localparam logic [7:0] OP_SUSP   = 8'hB0;
   localparam logic [7:0] OP_RESUME = 8'h30;
   localparam logic [7:0] OP_QUERY  = 8'h98;
   localparam logic [7:0] OP_SECID  = 8'h88;
   localparam logic [7:0] OP_EXIT   = 8'hF0;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_UNL1,
      SQ_UNL2,
      SQ_PROG,
      SQ_SETUP,
      SQ_ERS1,
      SQ_ERS2
   } seq_t;

   localparam int NUM_CMD = 9;

   typedef enum logic [3:0] {
      CM_NONE   = 4'd0,
      CM_PROG   = 4'd1,
      CM_SEC    = 4'd2,
      CM_BLK    = 4'd3,
      CM_CHIP   = 4'd4,
      CM_SUSP   = 4'd5,
      CM_RESUME = 4'd6,
      CM_QUERY  = 4'd7,
      CM_SECID  = 4'd8,
      CM_EXIT   = 4'd9
   } cmd_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
   import fcd_pkg::*;
#(
   parameter int CMP_W = 16
) (
   input  logic [CMP_W-1:0] addr_lo,
   input  logic [7:0]       data_lo,
   output logic             at_cmd,
   output logic             at_unl,
   output logic [7:0]       opcode
);
   initial begin
      if (CMP_W != 16) $error("fcd_match: compare width must be 16");
   end

   assign at_cmd = (addr_lo == ADR_CMD);
   assign at_unl = (addr_lo == ADR_UNL);
   assign opcode = data_lo;
endmodule

// File: rtl/fcd_protect.sv
module fcd_protect #(
   parameter int ADDR_W   = 22,
   parameter int BLOCK_W  = 15,
   parameter bit BOOT_TOP = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wp_n,
   output logic              blocked
);
   localparam int HI_W = ADDR_W - BLOCK_W;

   logic [HI_W-1:0] blk_idx;
   logic            in_boot;

   assign blk_idx = addr[ADDR_W-1:BLOCK_W];

   generate
      if (BOOT_TOP) begin : g_top
         assign in_boot = &blk_idx;
      end else begin : g_bottom
         assign in_boot = ~|blk_idx;
      end
   endgenerate

   assign blocked = in_boot & ~wp_n;
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
   import fcd_pkg::*;
#(
   parameter int ADDR_W   = 22,
   parameter int DATA_W   = 16,
   parameter int SECTOR_W = 11,
   parameter int BLOCK_W  = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [7:0]         opcode,
   input  logic               at_cmd,
   input  logic               at_unl,
   input  logic               blocked,
   input  logic               wp_n,
   input  logic               pgm_busy,
   input  logic               ers_busy,
   input  logic               ers_susp,
   output logic [NUM_CMD-1:0] cmd_q,
   output logic [ADDR_W-1:0]  op_addr,
   output logic [DATA_W-1:0]  op_data
);
   localparam logic [ADDR_W-1:0] SEC_MASK = {ADDR_W{1'b1}} << SECTOR_W;
   localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << BLOCK_W;
   localparam int BIT_SUSP   = int'(CM_SUSP) - 1;
   localparam int BIT_RESUME = int'(CM_RESUME) - 1;
   localparam int BIT_CHIP   = int'(CM_CHIP) - 1;
   localparam int BIT_PROG   = int'(CM_PROG) - 1;
   localparam int BIT_SEC    = int'(CM_SEC) - 1;
   localparam int BIT_BLK    = int'(CM_BLK) - 1;

   seq_t st_q, st_n;
   cmd_t fire;
   logic [NUM_CMD-1:0] cmd_n;

   always_comb begin
      st_n = st_q;
      fire = CM_NONE;
      if (wr_valid) begin
         if (pgm_busy || ers_busy) begin
            st_n = SQ_IDLE;
            if (ers_busy && opcode == OP_SUSP) fire = CM_SUSP;
         end else begin
            case (st_q)
               SQ_IDLE: begin
                  if (opcode == OP_UNL1 && at_cmd)        st_n = SQ_UNL1;
                  else if (opcode == OP_RESUME && ers_susp) fire = CM_RESUME;
                  else if (opcode == OP_EXIT)             fire = CM_EXIT;
               end
               SQ_UNL1: st_n = (opcode == OP_UNL2 && at_unl) ? SQ_UNL2 : SQ_IDLE;
               SQ_UNL2: begin
                  st_n = SQ_IDLE;
                  if (at_cmd) begin
                     case (opcode)
                        OP_PROG:  st_n = SQ_PROG;
                        OP_SETUP: st_n = SQ_SETUP;
                        OP_QUERY: fire = CM_QUERY;
                        OP_SECID: fire = CM_SECID;
                        OP_EXIT:  fire = CM_EXIT;
                        default:  st_n = SQ_IDLE;
                     endcase
                  end
               end
               SQ_PROG: begin
                  st_n = SQ_IDLE;
                  if (!blocked) fire = CM_PROG;
               end
               SQ_SETUP: st_n = (opcode == OP_UNL1 && at_cmd) ? SQ_ERS1 : SQ_IDLE;
               SQ_ERS1:  st_n = (opcode == OP_UNL2 && at_unl) ? SQ_ERS2 : SQ_IDLE;
               SQ_ERS2: begin
                  st_n = SQ_IDLE;
                  if (!ers_susp) begin
                     case (opcode)
                        OP_SEC:  if (!blocked) fire = CM_SEC;
                        OP_BLK:  if (!blocked) fire = CM_BLK;
                        OP_CHIP: if (at_cmd && wp_n) fire = CM_CHIP;
                        default: fire = CM_NONE;
                     endcase
                  end
               end
               default: st_n = SQ_IDLE;
            endcase
         end
      end
   end

   generate
      for (genvar gi = 0; gi < NUM_CMD; gi++) begin : g_dec
         assign cmd_n[gi] = (fire == cmd_t'(gi + 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         cmd_q   <= '0;
         op_addr <= '0;
         op_data <= '0;
      end else begin
         st_q  <= st_n;
         cmd_q <= cmd_n;
         case (fire)
            CM_PROG: begin
               op_addr <= wr_addr;
               op_data <= wr_data;
            end
            CM_SEC:  op_addr <= wr_addr & SEC_MASK;
            CM_BLK:  op_addr <= wr_addr & BLK_MASK;
            default: op_addr <= op_addr;
         endcase
      end
   end

   AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_q)); // R13
   AST_WRITE_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> (cmd_q == '0)); // R13
   AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (pgm_busy || ers_busy)) |=> ((cmd_q & ~(NUM_CMD'(1) << BIT_SUSP)) == '0)); // R8
   AST_SUSP_ONLY_ERASING: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !ers_busy) |=> !cmd_q[BIT_SUSP]); // R5
   AST_RESUME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !ers_susp) |=> !cmd_q[BIT_RESUME]); // R5
   AST_WP_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wp_n) |=> !cmd_q[BIT_CHIP]); // R9
   AST_WP_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && blocked) |=> !(cmd_q[BIT_PROG] || cmd_q[BIT_SEC] || cmd_q[BIT_BLK])); // R9
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W   = 22,
   parameter int DATA_W   = 16,
   parameter int SECTOR_W = 11,
   parameter int BLOCK_W  = 15,
   parameter bit BOOT_TOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wp_n,
   input  logic              pgm_busy,
   input  logic              ers_busy,
   input  logic              ers_susp,
   output logic              cmd_prog,
   output logic              cmd_sec_erase,
   output logic              cmd_blk_erase,
   output logic              cmd_chip_erase,
   output logic              cmd_suspend,
   output logic              cmd_resume,
   output logic              cmd_query_enter,
   output logic              cmd_secid_enter,
   output logic              cmd_exit,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);
   localparam int CMP_W = 16;

   generate
      if (ADDR_W < CMP_W || ADDR_W <= BLOCK_W) begin : g_bad_addr
         $error("flash_cmd_decoder: ADDR_W too small");
      end
      if (SECTOR_W >= BLOCK_W) begin : g_bad_geom
         $error("flash_cmd_decoder: sector must be smaller than block");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("flash_cmd_decoder: DATA_W below 8");
      end
   endgenerate

   logic               at_cmd, at_unl, blocked;
   logic [7:0]         opcode;
   logic [NUM_CMD-1:0] cmd_q;

   fcd_match #(.CMP_W(CMP_W)) u_match (
      .addr_lo (wr_addr[CMP_W-1:0]),
      .data_lo (wr_data[7:0]),
      .at_cmd  (at_cmd),
      .at_unl  (at_unl),
      .opcode  (opcode)
   );

   fcd_protect #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .BOOT_TOP(BOOT_TOP)) u_protect (
      .addr    (wr_addr),
      .wp_n    (wp_n),
      .blocked (blocked)
   );

   fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .opcode   (opcode),
      .at_cmd   (at_cmd),
      .at_unl   (at_unl),
      .blocked  (blocked),
      .wp_n     (wp_n),
      .pgm_busy (pgm_busy),
      .ers_busy (ers_busy),
      .ers_susp (ers_susp),
      .cmd_q    (cmd_q),
      .op_addr  (op_addr),
      .op_data  (op_data)
   );

   assign cmd_prog        = cmd_q[int'(CM_PROG)   - 1];
   assign cmd_sec_erase   = cmd_q[int'(CM_SEC)    - 1];
   assign cmd_blk_erase   = cmd_q[int'(CM_BLK)    - 1];
   assign cmd_chip_erase  = cmd_q[int'(CM_CHIP)   - 1];
   assign cmd_suspend     = cmd_q[int'(CM_SUSP)   - 1];
   assign cmd_resume      = cmd_q[int'(CM_RESUME) - 1];
   assign cmd_query_enter = cmd_q[int'(CM_QUERY)  - 1];
   assign cmd_secid_enter = cmd_q[int'(CM_SECID)  - 1];
   assign cmd_exit        = cmd_q[int'(CM_EXIT)   - 1];
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
   localparam int AW = 22;
   localparam int WD_LIMIT = 20000;

   // expected pulse codes: 0 none, 1 prog, 2 sector, 3 block, 4 chip,
   // 5 suspend, 6 resume, 7 query, 8 secid, 9 exit
   typedef struct packed {
      logic [3:0]    code;
      logic [7:0]    req;
      logic [AW-1:0] addr;
      logic [15:0]   data;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [15:0]   wr_data = '0;
   logic          wp_n = 1'b1;
   logic          pgm_busy = 1'b0;
   logic          ers_busy = 1'b0;
   logic          ers_susp = 1'b0;
   logic cmd_prog, cmd_sec_erase, cmd_blk_erase, cmd_chip_erase, cmd_suspend;
   logic cmd_resume, cmd_query_enter, cmd_secid_enter, cmd_exit;
   logic [AW-1:0] op_addr;
   logic [15:0]   op_data;

   exp_t exp_q[$];
   int mon_checks = 0, mon_fails = 0, main_checks = 0, main_fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   flash_cmd_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .wp_n(wp_n), .pgm_busy(pgm_busy), .ers_busy(ers_busy),
      .ers_susp(ers_susp), .cmd_prog(cmd_prog), .cmd_sec_erase(cmd_sec_erase),
      .cmd_blk_erase(cmd_blk_erase), .cmd_chip_erase(cmd_chip_erase),
      .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
      .cmd_query_enter(cmd_query_enter), .cmd_secid_enter(cmd_secid_enter),
      .cmd_exit(cmd_exit), .op_addr(op_addr), .op_data(op_data)
   );

   function automatic int obs_code();
      logic [8:0] v;
      v = {cmd_exit, cmd_secid_enter, cmd_query_enter, cmd_resume, cmd_suspend,
           cmd_chip_erase, cmd_blk_erase, cmd_sec_erase, cmd_prog};
      if ($countones(v) > 1) return 15;
      for (int i = 0; i < 9; i++) if (v[i]) return i + 1;
      return 0;
   endfunction

   // driver: one write, one idle cycle; pushes the expectation
   task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input int code,
                     input int req, input logic [AW-1:0] ea = '0, input logic [15:0] ed = '0);
      exp_t e;
      e.code = code[3:0]; e.req = req[7:0]; e.addr = ea; e.data = ed;
      @(negedge clk);
      wr_addr = a; wr_data = d; wr_valid = 1'b1;
      exp_q.push_back(e);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic unlock(input int req);
      wr(22'h005555, 16'h00AA, 0, req);
      wr(22'h002AAA, 16'h0055, 0, req);
   endtask

   task automatic erase_prefix(input int req);
      unlock(req);
      wr(22'h005555, 16'h0080, 0, req);
      unlock(req);
   endtask

   // monitor: compares every write's outcome with the queue head
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (wr_valid) begin
               if (exp_q.size() == 0) begin
                  mon_checks++; mon_fails++;
                  $display("FAIL R13: write with no expectation, actual code %0d expected none", obs_code());
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  mon_checks++;
                  if (obs_code() != int'(e.code)) begin
                     mon_fails++;
                     $display("FAIL R%0d: pulse code actual %0d expected %0d", e.req, obs_code(), e.code);
                  end else if (e.code >= 1 && e.code <= 3) begin
                     mon_checks++;
                     if (op_addr != e.addr || (e.code == 1 && op_data != e.data)) begin
                        mon_fails++;
                        $display("FAIL R%0d: op_addr/op_data actual %h/%h expected %h/%h",
                                 e.req, op_addr, op_data, e.addr, e.data);
                     end
                  end
               end
            end else if (obs_code() != 0) begin
               mon_checks++; mon_fails++;
               $display("FAIL R13: pulse without write, actual code %0d expected 0", obs_code());
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", mon_checks + main_checks + 1,
                  mon_fails + main_fails + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      main_checks++;
      if (obs_code() != 0 || op_addr != '0 || op_data != '0) begin
         main_fails++;
         $display("FAIL R13: reset state actual code %0d addr %h expected 0", obs_code(), op_addr);
      end

      // R1 program
      unlock(1); wr(22'h005555, 16'h00A0, 0, 1);
      wr(22'h123456, 16'hBEEF, 1, 1, 22'h123456, 16'hBEEF);
      // R11 upper data byte ignored in command cycles
      wr(22'h005555, 16'hFFAA, 0, 11); wr(22'h002AAA, 16'h1255, 0, 11);
      wr(22'h005555, 16'h77A0, 0, 11);
      wr(22'h200001, 16'h1234, 1, 11, 22'h200001, 16'h1234);
      // R2 sector erase, aligned to 2 KWord
      erase_prefix(2); wr(22'h2345AB, 16'h0030, 2, 2, 22'h234000);
      // R3 block erase, aligned to 32 KWord
      erase_prefix(3); wr(22'h2345AB, 16'h0050, 3, 3, 22'h230000);
      // R4 chip erase at 5555H only
      erase_prefix(4); wr(22'h005555, 16'h0010, 4, 4);
      erase_prefix(4); wr(22'h001234, 16'h0010, 0, 4);
      // R6 query, security-ID, exit forms
      unlock(6); wr(22'h005555, 16'h0098, 7, 6);
      unlock(6); wr(22'h005555, 16'h0088, 8, 6);
      unlock(6); wr(22'h005555, 16'h00F0, 9, 6);
      wr(22'h3F0000, 16'h00F0, 9, 6);
      // R7 abort: wrong unlock address, then A0 not reinterpreted
      wr(22'h005555, 16'h00AA, 0, 7); wr(22'h002AAB, 16'h0055, 0, 7);
      wr(22'h005555, 16'h00A0, 0, 7); wr(22'h100000, 16'h5A5A, 0, 7);
      // R7 repeated AA aborts; following 55 and 98 start nothing
      wr(22'h005555, 16'h00AA, 0, 7); wr(22'h005555, 16'h00AA, 0, 7);
      wr(22'h002AAA, 16'h0055, 0, 7); wr(22'h005555, 16'h0098, 0, 7);
      // R7 unknown third-cycle command
      unlock(7); wr(22'h005555, 16'h0077, 0, 7);

      // R9/R10 write protect with bottom boot block
      wp_n = 1'b0;
      unlock(9); wr(22'h005555, 16'h00A0, 0, 9); wr(22'h001000, 16'hAAAA, 0, 9);
      unlock(10); wr(22'h005555, 16'h00A0, 0, 10); wr(22'h007FFF, 16'hAAAA, 0, 10);
      unlock(9); wr(22'h005555, 16'h00A0, 0, 9);
      wr(22'h100000, 16'h4321, 1, 9, 22'h100000, 16'h4321);
      erase_prefix(9); wr(22'h007800, 16'h0030, 0, 9);
      erase_prefix(9); wr(22'h004000, 16'h0050, 0, 9);
      erase_prefix(9); wr(22'h005555, 16'h0010, 0, 9);
      erase_prefix(10); wr(22'h008000, 16'h0030, 2, 10, 22'h008000);
      wp_n = 1'b1;
      unlock(9); wr(22'h005555, 16'h00A0, 0, 9);
      wr(22'h000010, 16'h0F0F, 1, 9, 22'h000010, 16'h0F0F);

      // R8 busy lockout during program
      pgm_busy = 1'b1;
      unlock(8); wr(22'h005555, 16'h00A0, 0, 8); wr(22'h100000, 16'h1111, 0, 8);
      wr(22'h000000, 16'h00F0, 0, 8);
      wr(22'h003000, 16'h00B0, 0, 8);
      pgm_busy = 1'b0;
      // R5 suspend only while erasing; R8 exit still locked out
      ers_busy = 1'b1;
      wr(22'h005555, 16'h00AA, 0, 8);
      wr(22'h005555, 16'h00F0, 0, 8);
      wr(22'h003000, 16'h00B0, 5, 5);
      ers_busy = 1'b0;
      wr(22'h003000, 16'h00B0, 0, 5);
      // R12 erase dropped and program accepted while suspended
      ers_susp = 1'b1;
      erase_prefix(12); wr(22'h234000, 16'h0030, 0, 12);
      unlock(12); wr(22'h005555, 16'h00A0, 0, 12);
      wr(22'h300000, 16'hC0DE, 1, 12, 22'h300000, 16'hC0DE);
      // R7 30H right after an unlock byte only aborts; R5 then resume
      wr(22'h005555, 16'h00AA, 0, 7); wr(22'h000ABC, 16'h0030, 0, 7);
      wr(22'h000ABC, 16'h0030, 6, 5);
      ers_susp = 1'b0;
      wr(22'h000ABC, 16'h0030, 0, 5);

      repeat (3) @(negedge clk);
      main_checks++;
      if (exp_q.size() != 0) begin
         main_fails++;
         $display("FAIL R13: unconsumed expectations actual %0d expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", mon_checks + main_checks,
               mon_fails + main_fails);
      $finish;
   end
endmodule